// File: doc/BRIEF.md
# Full-Duplex Serial DMA Channel Pair

This block serves one full-duplex serial peripheral with two DMA channels that work side by side. The transmit channel reads words from memory and hands them to the peripheral's transmit side. The receive channel takes words from the peripheral's receive side and writes them to memory. Neither channel is started by software. Each channel moves one word every time the peripheral raises its ready request and the channel is granted the memory port.

Each channel holds four registers: a current pointer, a current count, a queued pointer and a queued count. When the current buffer runs out, the queued buffer takes its place in the following cycle. Software can therefore keep a stream going by refilling the queued pair while the current buffer drains. When both buffers are exhausted, the channel stops and raises an end flag.

There is a single memory port. If both channels can move a word in the same cycle, the receive side gets the port so that incoming data is never dropped.

Top module: `duplex_dma_pair`

## Requirements
- R1: After a synchronous reset, all eight channel registers read as zero, both end flags are 0, and no acknowledge or memory enable is asserted.
- R2: A register write updates the register selected by reg_addr. Bit 2 selects the channel (0 = transmit, 1 = receive). Bits 1:0 select the register: 0 = current pointer, 1 = current count, 2 = queued pointer, 3 = queued count. Count registers take the low 16 bits of the write data and read back zero-extended to 32 bits.
- R3: A transmit word moves when tx_req is high and the transmit count is nonzero, provided the receive side is not served. In that same cycle, tx_ack and mem_rd_en are 1, mem_addr equals the transmit pointer, and tx_data equals mem_rdata.
- R4: A receive word moves when rx_req is high and the receive count is nonzero. In that same cycle, rx_ack and mem_wr_en are 1, mem_addr equals the receive pointer, and mem_wdata equals rx_data.
- R5: Each word moved adds DATA_W/8 (4 by default) to that channel's pointer and removes 1 from its count, as seen from the next cycle.
- R6: When both channels are eligible in the same cycle, only the receive channel is served, and tx_ack stays 0.
- R7: A request to a channel whose current count is zero is ignored. No acknowledge and no memory access result, and the channel's registers are left unchanged.
- R8: When the last word of the current buffer moves and the queued count is nonzero, the next cycle shows the queued pointer and count as current, a queued count of zero, and an end flag that is still 0.
- R9: A channel whose current count is zero and whose queued count is nonzero loads the queued pair one cycle later, even with no request present.
- R10: A channel's end flag rises after its last word moves while its queued count is zero. It is cleared by writing a nonzero value to that channel's current or queued count. Writing zero leaves it set.
- R11: A register write to a channel blocks that channel from being served in the same cycle. The other channel can still be served in that cycle.
- R12: mem_rd_en and mem_wr_en are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Channel and register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the register selected by reg_addr |
| tx_req | input | 1 | Peripheral is ready to accept a transmit word |
| tx_ack | output | 1 | A transmit word is delivered this cycle |
| tx_data | output | 32 | Transmit word |
| rx_req | input | 1 | Peripheral holds a received word |
| rx_ack | output | 1 | The received word is taken this cycle |
| rx_data | input | 32 | Received word |
| mem_rd_en | output | 1 | Memory read enable |
| mem_wr_en | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle |
| tx_end | output | 1 | Transmit buffers exhausted |
| rx_end | output | 1 | Receive buffers exhausted |

## Verification
The bench targets the chaining corner cases.

- **Last word with a queued buffer.** The word that empties the current buffer while a queued buffer is waiting must hand over to the queued pointer. A design that reloads one word late would read from the old pointer's next address. A design that forgets to clear the queued count would replay the queued buffer.
- **Arbitration and write blocking.** Simultaneous requests must go to the receive side only. A register write to a channel must block that channel's service in the same cycle. A wrong arbiter would acknowledge both sides or lose receive data. A design that lets a write and a transfer collide would corrupt the count.
- **End flag.** A write of zero must not clear the end flag.
- **Exhausted channel.** A request to an exhausted channel must produce no acknowledge.

// File: rtl/ddp_pkg.sv
package ddp_pkg;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int NCH    = 2;
    localparam int CH_TX  = 0;
    localparam int CH_RX  = 1;

    typedef enum logic [1:0] {
        SEL_PTR  = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_NPTR = 2'd2,
        SEL_NCNT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] nptr;
        logic [CNT_W-1:0]  ncnt;
    } chan_regs_t;

    function automatic logic [ADDR_W-1:0] read_field(chan_regs_t r, reg_sel_e s);
        case (s)
            SEL_PTR:  return r.ptr;
            SEL_CNT:  return ADDR_W'(r.cnt);
            SEL_NPTR: return r.nptr;
            default:  return ADDR_W'(r.ncnt);
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] step_ptr(logic [ADDR_W-1:0] p, int step);
        return p + ADDR_W'(step);
    endfunction

endpackage

// File: rtl/ddp_chan.sv
module ddp_chan
    import ddp_pkg::*;
#(
    parameter int STEP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              serve,
    output chan_regs_t        regs,
    output logic              active,
    output logic              end_flag
);

    logic [CNT_W-1:0] wr_cnt;
    logic             last_word;
    logic             idle_reload;

    assign wr_cnt      = wr_data[CNT_W-1:0];
    assign active      = (regs.cnt != '0);
    assign last_word   = (regs.cnt == CNT_W'(1));
    assign idle_reload = !wr_en && !active && (regs.ncnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs     <= '0;
            end_flag <= 1'b0;
        end else begin
            if (serve) begin
                if (last_word && regs.ncnt != '0) begin
                    regs.ptr  <= regs.nptr;
                    regs.cnt  <= regs.ncnt;
                    regs.ncnt <= '0;
                end else begin
                    regs.ptr <= step_ptr(regs.ptr, STEP);
                    regs.cnt <= regs.cnt - CNT_W'(1);
                    if (last_word) begin
                        end_flag <= 1'b1;
                    end
                end
            end else if (idle_reload) begin
                regs.ptr  <= regs.nptr;
                regs.cnt  <= regs.ncnt;
                regs.ncnt <= '0;
            end
            if (wr_en) begin
                case (wr_sel)
                    SEL_PTR:  regs.ptr  <= wr_data;
                    SEL_NPTR: regs.nptr <= wr_data;
                    SEL_CNT: begin
                        regs.cnt <= wr_cnt;
                        if (wr_cnt != '0) end_flag <= 1'b0;
                    end
                    default: begin
                        regs.ncnt <= wr_cnt;
                        if (wr_cnt != '0) end_flag <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/ddp_arb.sv
module ddp_arb #(
    parameter int N = 2
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    always_comb begin
        gnt = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/duplex_dma_pair.sv
module duplex_dma_pair
    import ddp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              tx_req,
    output logic              tx_ack,
    output logic [DATA_W-1:0] tx_data,
    input  logic              rx_req,
    output logic              rx_ack,
    input  logic [DATA_W-1:0] rx_data,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              tx_end,
    output logic              rx_end
);

    localparam int UNIT_BYTES = DATA_W / 8;

    chan_regs_t       regs [NCH];
    logic [NCH-1:0]   active;
    logic [NCH-1:0]   endf;
    logic [NCH-1:0]   wr_ch;
    logic [NCH-1:0]   elig;
    logic [NCH-1:0]   gnt;
    reg_sel_e         sel;

    assign sel = reg_sel_e'(reg_addr[1:0]);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign wr_ch[c] = reg_wr && (reg_addr[2] == 1'(c));
        ddp_chan #(.STEP(UNIT_BYTES)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_ch[c]),
            .wr_sel   (sel),
            .wr_data  (reg_wdata),
            .serve    (gnt[c]),
            .regs     (regs[c]),
            .active   (active[c]),
            .end_flag (endf[c])
        );
    end

    assign elig = {rx_req, tx_req} & active & ~wr_ch;

    ddp_arb #(.N(NCH)) u_arb (
        .req (elig),
        .gnt (gnt)
    );

    assign tx_ack    = gnt[CH_TX];
    assign rx_ack    = gnt[CH_RX];
    assign mem_rd_en = gnt[CH_TX];
    assign mem_wr_en = gnt[CH_RX];
    assign mem_addr  = gnt[CH_RX] ? regs[CH_RX].ptr : regs[CH_TX].ptr;
    assign mem_wdata = rx_data;
    assign tx_data   = mem_rdata;
    assign reg_rdata = read_field(regs[reg_addr[2]], sel);
    assign tx_end    = endf[CH_TX];
    assign rx_end    = endf[CH_RX];

endmodule

// File: rtl/ddp_checker.sv
module ddp_checker #(
    parameter int STEP = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        tx_ack,
    input logic        rx_req,
    input logic        rx_ack,
    input logic        rx_wr,
    input logic        mem_rd_en,
    input logic        mem_wr_en,
    input logic        tx_end,
    input logic [15:0] tx_cnt,
    input logic [15:0] rx_cnt,
    input logic [31:0] rx_ptr
);

    // R12
    one_access_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));

    // R7
    idle_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_cnt == 16'd0) |-> !tx_ack);

    // R6
    rx_first_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_req && rx_cnt != 16'd0 && !rx_wr) |-> (rx_ack && !tx_ack));

    // R5
    rx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_ack && rx_cnt > 16'd1 && !rx_wr) |=>
        (rx_ptr == $past(rx_ptr) + 32'(STEP) && rx_cnt == $past(rx_cnt) - 16'd1));

    // R10
    end_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_end) |-> $past(tx_ack));

endmodule

bind duplex_dma_pair ddp_checker #(.STEP(UNIT_BYTES)) u_ddp_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_ack    (tx_ack),
    .rx_req    (rx_req),
    .rx_ack    (rx_ack),
    .rx_wr     (reg_wr && reg_addr[2]),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .tx_end    (tx_end),
    .tx_cnt    (regs[0].cnt),
    .rx_cnt    (regs[1].cnt),
    .rx_ptr    (regs[1].ptr)
);

// File: tb/duplex_dma_pair_bench.sv
module duplex_dma_pair_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        tx_req = 1'b0, rx_req = 1'b0;
    logic        tx_ack, rx_ack;
    logic [31:0] tx_data, rx_data, mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd_en, mem_wr_en, tx_end, rx_end;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    assign mem_rdata = 32'hA500_0000 ^ mem_addr;
    assign rx_data   = 32'h5A00_0000 | 32'(mem_addr[15:0]);

    duplex_dma_pair u_duplex_dma_pair (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_req(tx_req), .tx_ack(tx_ack), .tx_data(tx_data),
        .rx_req(rx_req), .rx_ack(rx_ack), .rx_data(rx_data),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_end(tx_end), .rx_end(rx_end)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // {tx_req, rx_req, exp_tx_ack, exp_rx_ack, exp_addr}
    localparam logic [35:0] VEC [9] = '{
        {4'b1010, 32'h0000_0100},
        {4'b1101, 32'h0000_0400},
        {4'b1010, 32'h0000_0104},
        {4'b0101, 32'h0000_0404},
        {4'b1110, 32'h0000_0108},
        {4'b1110, 32'h0000_0200},
        {4'b0000, 32'h0000_0000},
        {4'b1010, 32'h0000_0204},
        {4'b1100, 32'h0000_0000}
    };

    initial begin
        #(4 * 200000);
        total++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reg zero", v, 32'd0);
        end
        chk("R1 acks", {30'd0, tx_ack, rx_ack}, 32'd0);
        chk("R1 mem en", {30'd0, mem_rd_en, mem_wr_en}, 32'd0);
        chk("R1 end flags", {30'd0, tx_end, rx_end}, 32'd0);

        // R2 register map and zero-extended count
        wr(3'd1, 32'hFFFF_1234);
        rd(3'd1, v); chk("R2 count zero-extended", v, 32'h0000_1234);
        wr(3'd6, 32'hDEAD_BEEF);
        rd(3'd6, v); chk("R2 rx queued pointer", v, 32'hDEAD_BEEF);

        // setup of the streaming scenario
        wr(3'd0, 32'h100); wr(3'd1, 32'd3);
        wr(3'd2, 32'h200); wr(3'd3, 32'd2);
        wr(3'd4, 32'h400); wr(3'd5, 32'd2);
        wr(3'd6, 32'h0);
        rd(3'd3, v); chk("R2 tx queued count", v, 32'd2);

        // table walk: R3 R4 R5 R6 R7 R8 R12
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            tx_req = VEC[i][35]; rx_req = VEC[i][34];
            #1;
            chk($sformatf("R6 R7 tx_ack step %0d", i), {31'd0, tx_ack}, {31'd0, VEC[i][33]});
            chk($sformatf("R4 R6 rx_ack step %0d", i), {31'd0, rx_ack}, {31'd0, VEC[i][32]});
            chk($sformatf("R12 step %0d", i), {31'd0, mem_rd_en && mem_wr_en}, 32'd0);
            if (VEC[i][33]) begin
                chk($sformatf("R3 R5 R8 tx addr %0d", i), mem_addr, VEC[i][31:0]);
                chk($sformatf("R3 tx data %0d", i), tx_data, 32'hA500_0000 ^ VEC[i][31:0]);
            end
            if (VEC[i][32]) begin
                chk($sformatf("R4 R5 rx addr %0d", i), mem_addr, VEC[i][31:0]);
                chk($sformatf("R4 rx data %0d", i), mem_wdata, rx_data);
            end
        end
        @(negedge clk);
        tx_req = 1'b0; rx_req = 1'b0;
        #1;
        rd(3'd0, v); chk("R5 R8 tx pointer", v, 32'h208);
        rd(3'd1, v); chk("R7 tx count", v, 32'd0);
        rd(3'd3, v); chk("R8 queued count cleared", v, 32'd0);
        rd(3'd4, v); chk("R5 rx pointer", v, 32'h408);
        chk("R10 end flags set", {30'd0, tx_end, rx_end}, 32'd3);

        // R10 zero write keeps flag, nonzero clears
        wr(3'd1, 32'd0);
        chk("R10 zero write keeps", {31'd0, tx_end}, 32'd1);
        wr(3'd1, 32'd1);
        chk("R10 nonzero clears", {31'd0, tx_end}, 32'd0);

        // R9 idle reload on receive
        wr(3'd6, 32'h600); wr(3'd7, 32'd3);
        chk("R10 queued count write clears", {31'd0, rx_end}, 32'd0);
        @(negedge clk);
        rd(3'd4, v); chk("R9 idle reload pointer", v, 32'h600);
        rd(3'd5, v); chk("R9 idle reload count", v, 32'd3);
        rd(3'd7, v); chk("R9 queued count cleared", v, 32'd0);

        // R11 write blocks own channel, other side served
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h300;
        tx_req = 1'b1; rx_req = 1'b1;
        #1;
        chk("R11 tx blocked by write", {31'd0, tx_ack}, 32'd0);
        chk("R11 rx served", {31'd0, rx_ack}, 32'd1);
        chk("R11 rx addr", mem_addr, 32'h600);
        @(negedge clk);
        reg_wr = 1'b0; rx_req = 1'b0;
        #1;
        chk("R11 tx served after", {31'd0, tx_ack}, 32'd1);
        chk("R3 tx addr after", mem_addr, 32'h208);
        @(negedge clk);
        tx_req = 1'b0;
        #1;
        chk("R10 tx end after last", {31'd0, tx_end}, 32'd1);
        rd(3'd4, v); chk("R5 rx pointer after", v, 32'h604);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule